// File: doc/BRIEF.md
# Low-Droop Logic Self-Test Pattern Controller

This block drives the scan chains of a circuit under test with pseudo-random patterns and compacts the responses into a signature. A 16-bit linear feedback shift register feeds a phase shifter. The phase shifter produces one bit per scan chain on every generation clock, and a run of `CHAIN_LEN` such slices makes up one test vector. The block applies `NUM_ORIG` of these original vectors in a fixed order. Each vector is shifted in with scan enable high and then captured in a single clock with scan enable low.

Between two consecutive original vectors, the controller can insert up to three substitute vectors, each with its own shift and capture. Every substitute is built from the original vector just applied and the original vector that comes next. Each chain takes its bits from one of those two vectors, and a threshold sets which chains take the next vector; that threshold moves further with each later substitute. The bits that change between captures are therefore spread over several smaller steps, which lowers the peak switching activity and the supply droop it causes. The originals are left untouched, so fault coverage stays the same.

A debug output gives the Hamming distance from each applied vector to the vector applied before it. After the last capture, one more shift unloads the chains. Done then rises, and the signature stays on its port until the next start.

Top module: `lbist_lowdroop_ctrl`

## Requirements
- R1: After reset, `test_done` and `scan_en` are low, `chain_si` is zero and `step_dist` is zero.
- R2: The generator starts at `SEED` on every start and steps as s' = {s[14:0], s[15]^s[14]^s[12]^s[3]}. In each generation clock, chain c receives s[c]^s[(c+5)%16]^s[(c+11)%16] from the current state, and the state then steps. Slice k of a vector goes out on `chain_si` in the k-th shift cycle of that vector. The originals appear in generation order, `NUM_ORIG` of them, whatever the substitute count.
- R3: Exactly m substitute vectors are applied between each pair of consecutive originals, and none after the last original. m is `sub_cnt_cfg` sampled at the start; changing it later in the run has no effect.
- R4: Substitute j of m (j = 1..m) carries the next original's bits on chains c >= NC - floor(j*NC/(m+1)). It carries the previous original's bits on all other chains.
- R5: The largest `step_dist` seen in a run with m >= 1 never exceeds the largest seen with m = 0.
- R6: Each applied vector takes exactly `CHAIN_LEN` cycles with `scan_en` high, followed by exactly one capture cycle with `scan_en` low before the next burst.
- R7: After the capture of the last original, one unload burst of `CHAIN_LEN` shift cycles follows with `chain_si` zero. `test_done` then rises.
- R8: The signature starts at zero on each start. In every cycle with `scan_en` high it updates as m' = {m[14:0], m[15]^m[14]^m[12]^m[3]} ^ zero-extended `chain_so`.
- R9: While a vector is being shifted, `step_dist` equals its Hamming distance to the vector applied before it. The all-zero vector counts as the one before the first.
- R10: `test_done` and `signature` hold steady until the next start. A start while done begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_start | input | 1 | Begins a run when the block is idle or done |
| sub_cnt_cfg | input | SUBW | Substitute vectors per original pair, sampled at start |
| test_done | output | 1 | High once the run is finished |
| scan_en | output | 1 | Shift enable to the scan chains |
| chain_si | output | NC | One scan-in bit per chain |
| chain_so | input | NC | One scan-out bit per chain |
| signature | output | 16 | Compacted response |
| step_dist | output | $clog2(NC*CHAIN_LEN+1) | Hamming distance of the current vector to the one before |

## Verification
If the generator state or the phase shifter goes wrong, the error appears on `chain_si` in the very first shift cycle it affects. The bench compares every slice against vectors it rebuilds on its own. A wrong substitute threshold or a wrong sequencing counter also shows up in the first slice of the affected vector, and it shifts every later burst, which breaks the count of captures and the one-cycle gap between bursts. A fault in the compactor or the unload stays hidden until done, when the signature differs from the fold the bench keeps over `chain_so`.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  localparam int PRPG_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_PRIME, ST_SHIFT, ST_CAPTURE, ST_UNLOAD, ST_DONE
  } seq_state_t;

  // maximal-length feedback, taps 16,15,13,4
  function automatic logic [15:0] prpg_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  // three-tap XOR phase shifter: chain c sees bits c, c+5, c+11 (mod 16)
  function automatic logic [15:0] spread(input logic [15:0] s);
    logic [15:0] o;
    for (int c = 0; c < 16; c++)
      o[c] = s[c] ^ s[(c + 5) % 16] ^ s[(c + 11) % 16];
    return o;
  endfunction

  function automatic logic [15:0] misr_next(input logic [15:0] m, input logic [15:0] d);
    return {m[14:0], m[15] ^ m[14] ^ m[12] ^ m[3]} ^ d;
  endfunction

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
  import lbist_pkg::*;
#(
  parameter int NC = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  output logic [NC-1:0] slice
);
  logic [15:0] st;
  logic [15:0] spread_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= SEED;
    else if (load) st <= SEED;
    else if (step) st <= prpg_next(st);
  end

  assign spread_w = spread(st);
  assign slice    = spread_w[NC-1:0];

  // R2
  prpg_nz_chk: assert property (@(posedge clk) disable iff (!rst_n) st != 16'h0);
endmodule

// File: rtl/lbist_subgen.sv
module lbist_subgen #(
  parameter int NC   = 8,
  parameter int L    = 8,
  parameter int SUBW = 2,
  localparam int VW  = NC * L
) (
  input  logic [VW-1:0]   prev_vec,
  input  logic [VW-1:0]   next_vec,
  input  logic [SUBW-1:0] total,
  input  logic [SUBW-1:0] idx,
  output logic [VW-1:0]   sub_vec
);
  int thr;
  // chains at or above thr take the upcoming original
  always_comb thr = NC - (int'(idx) * NC) / (int'(total) + 1);

  for (genvar c = 0; c < NC; c++) begin : g_chain
    for (genvar i = 0; i < L; i++) begin : g_slice
      assign sub_vec[i*NC + c] = (c >= thr) ? next_vec[i*NC + c] : prev_vec[i*NC + c];
    end
  end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
  import lbist_pkg::*;
#(
  parameter int NC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic [NC-1:0] din,
  output logic [15:0]   sig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (en)    sig <= misr_next(sig, 16'(din));
  end
endmodule

// File: rtl/lbist_lowdroop_ctrl.sv
module lbist_lowdroop_ctrl
  import lbist_pkg::*;
#(
  parameter int NC        = 8,
  parameter int CHAIN_LEN = 8,
  parameter int NUM_ORIG  = 6,
  parameter int SUBW      = 2,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int VW = NC * CHAIN_LEN,
  localparam int DW = $clog2(VW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_start,
  input  logic [SUBW-1:0] sub_cnt_cfg,
  output logic            test_done,
  output logic            scan_en,
  output logic [NC-1:0]   chain_si,
  input  logic [NC-1:0]   chain_so,
  output logic [15:0]     signature,
  output logic [DW-1:0]   step_dist
);
  localparam int CW = $clog2(CHAIN_LEN);
  localparam int OW = $clog2(NUM_ORIG);

  seq_state_t    state;
  logic [CW-1:0] bit_cnt;
  logic [OW-1:0] orig_idx;
  logic [SUBW-1:0] sub_idx, sub_total, sub_idx_nx;
  logic [VW-1:0] cur, nxt, base, app;
  logic [VW-1:0] sub_vec, load_vec;
  logic [NC-1:0] slice;

  // named internal events
  logic last_bit, last_orig, to_sub, gen_on, run_go;
  assign last_bit   = (bit_cnt == CW'(CHAIN_LEN - 1));
  assign last_orig  = (orig_idx == OW'(NUM_ORIG - 1));
  assign to_sub     = (sub_idx < sub_total);
  assign gen_on     = (state == ST_FILL) ||
                      (state == ST_SHIFT && sub_idx == '0 && !last_orig);
  assign run_go     = test_start && (state == ST_IDLE || state == ST_DONE);
  assign sub_idx_nx = sub_idx + 1'b1;
  assign load_vec   = to_sub ? sub_vec : nxt;

  lbist_prpg #(.NC(NC), .SEED(SEED)) u_prpg (
    .clk(clk), .rst_n(rst_n), .load(run_go), .step(gen_on), .slice(slice)
  );

  lbist_subgen #(.NC(NC), .L(CHAIN_LEN), .SUBW(SUBW)) u_sub (
    .prev_vec(base), .next_vec(nxt), .total(sub_total), .idx(sub_idx_nx), .sub_vec(sub_vec)
  );

  lbist_misr #(.NC(NC)) u_misr (
    .clk(clk), .rst_n(rst_n), .clear(run_go), .en(scan_en), .din(chain_so), .sig(signature)
  );

  assign scan_en   = (state == ST_SHIFT) || (state == ST_UNLOAD);
  assign chain_si  = scan_en ? cur[NC-1:0] : '0;
  assign test_done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_cnt <= '0; orig_idx <= '0; sub_idx <= '0; sub_total <= '0;
      cur <= '0; nxt <= '0; base <= '0; app <= '0; step_dist <= '0;
    end else begin
      if (gen_on) nxt[int'(bit_cnt)*NC +: NC] <= slice;
      case (state)
        ST_IDLE, ST_DONE: if (run_go) begin
          state <= ST_FILL; bit_cnt <= '0; sub_total <= sub_cnt_cfg; app <= '0;
        end
        ST_FILL: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (last_bit) state <= ST_PRIME;
        end
        ST_PRIME: begin
          cur <= nxt; base <= nxt; app <= nxt;
          step_dist <= DW'($countones(nxt ^ app));
          orig_idx <= '0; sub_idx <= '0; bit_cnt <= '0; state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          cur <= cur >> NC;
          bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
          if (last_bit) state <= ST_CAPTURE;
        end
        ST_CAPTURE: begin
          bit_cnt <= '0;
          if (last_orig) state <= ST_UNLOAD;
          else begin
            cur <= load_vec; app <= load_vec;
            step_dist <= DW'($countones(load_vec ^ app));
            if (to_sub) sub_idx <= sub_idx_nx;
            else begin
              sub_idx <= '0; orig_idx <= orig_idx + 1'b1; base <= nxt;
            end
            state <= ST_SHIFT;
          end
        end
        ST_UNLOAD: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (last_bit) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  shift_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && last_bit) |=> (state == ST_CAPTURE && !scan_en));
  // R6
  capture_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPTURE) |=> scan_en);
  // R5
  dist_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPTURE && !last_orig && to_sub) |->
      ($countones(sub_vec ^ app) <= $countones(base ^ nxt)));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_done && $past(test_done) && !$past(test_start)) |-> $stable(signature));
endmodule

// File: tb/lbist_lowdroop_ctrl_test.sv
module lbist_lowdroop_ctrl_test;
  localparam int NC = 8, L = 8, N = 6, SUBW = 2;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam int VW = NC * L, DW = $clog2(VW + 1);
  localparam int MAXS = N + (N - 1) * 3;

  logic clk = 0, rst_n = 0, test_start = 0;
  logic [SUBW-1:0] sub_cnt_cfg = '0;
  logic test_done, scan_en;
  logic [NC-1:0] chain_si, chain_so;
  logic [15:0] signature;
  logic [DW-1:0] step_dist;

  int checks = 0, errors = 0;
  int peak [4];

  always #4 clk = ~clk;

  lbist_lowdroop_ctrl #(.NC(NC), .CHAIN_LEN(L), .NUM_ORIG(N), .SUBW(SUBW), .SEED(SEED)) uut (
    .clk(clk), .rst_n(rst_n), .test_start(test_start), .sub_cnt_cfg(sub_cnt_cfg),
    .test_done(test_done), .scan_en(scan_en), .chain_si(chain_si), .chain_so(chain_so),
    .signature(signature), .step_dist(step_dist)
  );

  // bench-side circuit under test: shift registers with a scrambling capture
  logic [L-1:0] chains [NC];
  logic en_q;
  for (genvar c = 0; c < NC; c++) begin : g_so
    assign chain_so[c] = chains[c][L-1];
  end
  always @(posedge clk) begin
    en_q <= scan_en;
    for (int c = 0; c < NC; c++) begin
      if (!rst_n) chains[c] <= '0;
      else if (scan_en) chains[c] <= {chains[c][L-2:0], chain_si[c]};
      else if (en_q) chains[c] <= ~{chains[c][0], chains[c][L-1:1]} ^ L'(c * 5 + 3);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] b_step(input logic [15:0] s);
    return (s << 1) | 16'(^(s & 16'hD008));
  endfunction
  function automatic logic [15:0] b_spread(input logic [15:0] s);
    return s ^ ((s >> 5) | (s << 11)) ^ ((s >> 11) | (s << 5));
  endfunction

  logic [VW-1:0] seq [MAXS];
  int nseq;

  task automatic build(input int m);
    logic [VW-1:0] orig [N];
    logic [15:0] s = SEED;
    for (int k = 0; k < N; k++)
      for (int i = 0; i < L; i++) begin
        logic [15:0] p = b_spread(s);
        orig[k][i*NC +: NC] = p[NC-1:0];
        s = b_step(s);
      end
    nseq = 0;
    for (int k = 0; k < N; k++) begin
      seq[nseq++] = orig[k];
      if (k < N - 1)
        for (int j = 1; j <= m; j++) begin
          int thr = NC - (j * NC) / (m + 1);
          logic [VW-1:0] v;
          for (int b = 0; b < VW; b++) v[b] = ((b % NC) >= thr) ? orig[k+1][b] : orig[k][b];
          seq[nseq++] = v;
        end
    end
  endtask

  task automatic run(input int m, input int other);
    int vidx = 0, scnt = 0, gap = 0, cyc = 0;
    bit prev_en = 0;
    logic [VW-1:0] prevv = '0;
    logic [15:0] emisr = '0, sig0;
    build(m);
    peak[m] = 0;
    @(negedge clk); test_start = 1; sub_cnt_cfg = SUBW'(m);
    @(negedge clk); test_start = 0; sub_cnt_cfg = SUBW'(other); // R3: ignored mid-run
    while (!test_done) begin
      if (scan_en) begin
        if (!prev_en) begin
          if (vidx > 0) chk(gap == 1, "R6 capture gap", gap, 1);
          if (vidx < nseq) begin
            int hd = $countones(seq[vidx] ^ prevv);
            chk(step_dist == DW'(hd), "R9 step_dist", step_dist, hd);
            if (hd > peak[m]) peak[m] = hd;
            prevv = seq[vidx];
          end
        end
        if (vidx < nseq) chk(chain_si == seq[vidx][scnt*NC +: NC], "R2/R4 slice", chain_si, seq[vidx][scnt*NC +: NC]);
        else chk(chain_si == '0, "R7 unload zero", chain_si, 0);
        emisr = b_step(emisr) ^ 16'(chain_so);
        scnt++;
        if (scnt == L) begin scnt = 0; vidx++; gap = 0; end
      end else if (vidx > 0) gap++;
      prev_en = scan_en;
      cyc++;
      if (cyc > 5000) begin chk(0, "watchdog", cyc, 0); break; end
      @(negedge clk);
    end
    chk(vidx == nseq + 1, "R3/R7 burst count", vidx, nseq + 1);
    chk(signature == emisr, "R8 signature", signature, emisr);
    sig0 = signature;
    repeat (5) @(negedge clk);
    chk(test_done && signature == sig0, "R10 hold", signature, sig0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!test_done && !scan_en, "R1 done/scan_en", {test_done, scan_en}, 0);
    chk(chain_si == '0 && step_dist == '0, "R1 si/dist", {chain_si, step_dist}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, 3);
    run(1, 0);   // R10 restart from done
    run(2, 1);
    run(3, 2);
    for (int m = 1; m < 4; m++) chk(peak[m] <= peak[0], "R5 peak", peak[m], peak[0]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule